// File: doc/BRIEF.md
# Key-Protected Watchdog Interval Timer

This peripheral counts divided clock periods in an 8-bit up-counter. Before the clock reaches the counter it goes through a prescaler, and a 3-bit select code in the control/status register sets the prescaler ratio. When the counter wraps from 0xFF to 0x00, the block does one of two things, chosen by a mode bit. In watchdog mode it sets a watchdog overflow flag and pulses a reset request. In interval mode it sets an interval overflow flag and holds an interrupt high for as long as that flag stays set.

Software reaches the block through a small register bus. The bus has a 1-bit address, a write strobe, 16-bit write data and 8-bit read data. Every write has to carry a key in its upper byte, and each register has its own key. A write with the wrong key is dropped. Reads need no key.

A typical watchdog use looks like this. Software selects the ratio and the mode, sets the enable bit, and then writes 0 to the counter often enough that it never wraps. Each counter write restarts the prescaler as well, so every restart gives a full, known period.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter reads 0x00, the control/status register reads 0x00 (enabled off, ratio code 0), and rst_req_o and irq_o are low.
- R2: A write to address 0 loads wdata_i[7:0] into the counter only when wdata_i[15:8] is 0x5A. With any other upper byte the counter keeps its value.
- R3: A write to address 1 takes effect only when wdata_i[15:8] is 0xA5. Any other upper byte leaves the register unchanged. The control/status layout is as follows. Bit 7 is enable. Bit 6 is the mode: 1 selects watchdog, 0 selects interval. Bit 5 is the reset kind. Bit 4 is the watchdog overflow flag. Bit 3 is the interval overflow flag. Bits 2:0 are the ratio code.
- R4: The counter advances once every 32 << code clock cycles. After enable rises, after a keyed counter write, or after a change of ratio code, the first advance comes a full period after the write edge.
- R5: The counter advances only while bit 7 is 1. While bit 7 is 0, both the counter and the prescaler are frozen.
- R6: In interval mode, a wrap from 0xFF to 0x00 sets bit 3. irq_o is high exactly while bit 3 is set.
- R7: In watchdog mode, a wrap sets bit 4 and drives rst_req_o high for one cycle. During that cycle rst_kind_o equals bit 5.
- R8: Writing 0 to a flag bit clears it. Writing 1 to a flag bit has no effect. If hardware sets a flag in the same cycle as a clear, the set wins.
- R9: rdata_o returns the counter when addr_i is 0 and the control/status register when addr_i is 1. It does so combinationally and with no key check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 1 | Register select: 0 counter, 1 control/status |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Key in bits 15:8, value in bits 7:0 |
| rdata_o | output | 8 | Selected register value |
| rst_req_o | output | 1 | One-cycle reset request on a watchdog wrap |
| rst_kind_o | output | 1 | Reset kind bit from the control/status register |
| irq_o | output | 1 | Interval overflow interrupt |

## Verification
Writes go to both registers with a correct key and with an off-by-one key. This separates key decoding from plain address decoding.

Counting is run at two ratio codes, with the advance time sampled one cycle before and one cycle after the expected edge. A wrong divide ratio or a prescaler that does not restart shows up as an off-by-one sample.

The counter is preloaded to 0xFE and to 0xFF, once in each mode. This checks that a wrap drives the interrupt output in one mode and the reset output in the other. The flag bits are written with 1 and with 0, and the counter is observed while disabled. Together these separate clear-only flags and frozen counting from flags that software can set and from free-running counting.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_MODE = 6;
  localparam int unsigned BIT_KIND = 5;
  localparam int unsigned BIT_WOVF = 4;
  localparam int unsigned BIT_IOVF = 3;

  typedef enum logic {
    SEL_CNT = 1'b0,
    SEL_CSR = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/keyed_wdt_prescaler.sv
module keyed_wdt_prescaler #(
  parameter int unsigned BASE_LOG2 = 5,
  parameter int unsigned CKS_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             tick_o
);
  localparam int unsigned PW = BASE_LOG2 + (1 << CKS_W) - 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] last;

  // terminal value: (32 << cks) - 1
  always_comb begin
    last = '0;
    for (int i = 0; i < (1 << CKS_W); i++) begin
      if (cks_i == CKS_W'(i)) last = PW'((1 << (BASE_LOG2 + i)) - 1);
    end
  end

  assign tick_o = en_i && !restart_i && (pcnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pcnt_q <= '0;
    else if (!en_i || restart_i)     pcnt_q <= '0;
    else if (pcnt_q == last)         pcnt_q <= '0;
    else                             pcnt_q <= pcnt_q + 1'b1;
  end

  // ratio >= 32, so ticks never come back to back
  assert_tick_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = tick_i && !load_i && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs #(
  parameter int unsigned CKS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wval_i,
  input  logic             set_wdt_i,
  input  logic             set_itv_i,
  output logic             en_o,
  output logic             mode_o,
  output logic             kind_o,
  output logic             wovf_o,
  output logic             iovf_o,
  output logic [CKS_W-1:0] cks_o
);
  import keyed_wdt_pkg::*;

  logic en_q, mode_q, kind_q, wovf_q, iovf_q;
  logic [CKS_W-1:0] cks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      kind_q <= 1'b0;
      cks_q  <= '0;
      wovf_q <= 1'b0;
      iovf_q <= 1'b0;
    end else begin
      if (wr_i) begin
        en_q   <= wval_i[BIT_EN];
        mode_q <= wval_i[BIT_MODE];
        kind_q <= wval_i[BIT_KIND];
        cks_q  <= wval_i[CKS_W-1:0];
        // software may clear, never set; hardware set wins
        wovf_q <= (wovf_q & wval_i[BIT_WOVF]) | set_wdt_i;
        iovf_q <= (iovf_q & wval_i[BIT_IOVF]) | set_itv_i;
      end else begin
        wovf_q <= wovf_q | set_wdt_i;
        iovf_q <= iovf_q | set_itv_i;
      end
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign kind_o = kind_q;
  assign cks_o  = cks_q;
  assign wovf_o = wovf_q;
  assign iovf_o = iovf_q;

  assert_wovf_hw_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wovf_q) |-> $past(set_wdt_i));
  assert_iovf_hw_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iovf_q) |-> $past(set_itv_i));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned CKS_W     = 3,
  parameter int unsigned BASE_LOG2 = 5,
  parameter logic [7:0]  KEY_CNT   = 8'h5A,
  parameter logic [7:0]  KEY_CSR   = 8'hA5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        addr_i,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  rdata_o,
  output logic        rst_req_o,
  output logic        rst_kind_o,
  output logic        irq_o
);
  import keyed_wdt_pkg::*;

  logic             cnt_wr, csr_wr, cks_chg, restart, tick, wrap;
  logic             en, mode, kind, wovf, iovf;
  logic [CKS_W-1:0] cks;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       csr;
  logic             rst_req_q;

  assign cnt_wr  = we_i && (reg_sel_e'(addr_i) == SEL_CNT) && (wdata_i[15:8] == KEY_CNT);
  assign csr_wr  = we_i && (reg_sel_e'(addr_i) == SEL_CSR) && (wdata_i[15:8] == KEY_CSR);
  assign cks_chg = csr_wr && (wdata_i[CKS_W-1:0] != cks);
  assign restart = cnt_wr || cks_chg;

  keyed_wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .CKS_W(CKS_W)) u_presc (
    .clk_i, .rst_ni, .en_i(en), .restart_i(restart), .cks_i(cks), .tick_o(tick)
  );

  keyed_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_wr), .load_val_i(wdata_i[CNT_W-1:0]),
    .tick_i(tick), .cnt_o(cnt), .wrap_o(wrap)
  );

  keyed_wdt_regs #(.CKS_W(CKS_W)) u_regs (
    .clk_i, .rst_ni, .wr_i(csr_wr), .wval_i(wdata_i[7:0]),
    .set_wdt_i(wrap && mode), .set_itv_i(wrap && !mode),
    .en_o(en), .mode_o(mode), .kind_o(kind), .wovf_o(wovf), .iovf_o(iovf), .cks_o(cks)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= wrap && mode;
  end

  always_comb begin
    csr           = '0;
    csr[BIT_EN]   = en;
    csr[BIT_MODE] = mode;
    csr[BIT_KIND] = kind;
    csr[BIT_WOVF] = wovf;
    csr[BIT_IOVF] = iovf;
    csr[CKS_W-1:0] = cks;
  end

  assign rdata_o    = (reg_sel_e'(addr_i) == SEL_CSR) ? csr : 8'(cnt);
  assign rst_req_o  = rst_req_q;
  assign rst_kind_o = kind;
  assign irq_o      = iovf;

  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  assert_bad_key_cnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i && wdata_i[15:8] != KEY_CNT && !en) |=> $stable(cnt));
  assert_bad_key_csr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && wdata_i[15:8] != KEY_CSR && !wrap) |=> $stable(csr));
  assert_irq_from_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(cnt) == '0 ? 1'b0 : 1'b1) && $past(!mode));
  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        rst_req_o, rst_kind_o, irq_o;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  keyed_wdt u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b0, v); chk("R1 cnt", v, 8'h00);
    rd(1'b1, v); chk("R1 csr", v, 8'h00);
    chk("R1 outs", {6'b0, rst_req_o, irq_o}, 8'h00);
  endtask

  task automatic t_keys;
    logic [7:0] v;
    bus_wr(1'b0, 16'h5B33); rd(1'b0, v); chk("R2 bad key cnt", v, 8'h00);
    bus_wr(1'b1, 16'hA4E7); rd(1'b1, v); chk("R3 bad key csr", v, 8'h00);
    bus_wr(1'b0, 16'h5A42); rd(1'b0, v); chk("R2 good key cnt", v, 8'h42);
    rd(1'b1, v);                          chk("R9 csr read", v, 8'h00);
    bus_wr(1'b1, 16'hA518); rd(1'b1, v); chk("R8 flag write 1", v, 8'h00);
    bus_wr(1'b1, 16'hA526); rd(1'b1, v); chk("R3 good key csr", v, 8'h26);
    wait_edges(100); rd(1'b0, v);        chk("R5 disabled hold", v, 8'h42);
  endtask

  task automatic t_ratio;
    logic [7:0] v;
    bus_wr(1'b0, 16'h5A00);
    bus_wr(1'b1, 16'hA580);
    wait_edges(31); rd(1'b0, v); chk("R4 div32 early", v, 8'h00);
    wait_edges(1);  rd(1'b0, v); chk("R4 div32 edge", v, 8'h01);
    bus_wr(1'b0, 16'h5A00);
    bus_wr(1'b1, 16'hA582);
    wait_edges(127); rd(1'b0, v); chk("R4 div128 early", v, 8'h00);
    wait_edges(1);   rd(1'b0, v); chk("R4 div128 edge", v, 8'h01);
  endtask

  task automatic t_interval;
    logic [7:0] v;
    bus_wr(1'b1, 16'hA580);
    bus_wr(1'b0, 16'h5AFE);
    wait_edges(63); chk("R6 irq before wrap", {7'b0, irq_o}, 8'h00);
    wait_edges(1);
    chk("R6 irq on wrap", {7'b0, irq_o}, 8'h01);
    rd(1'b1, v); chk("R6 iovf flag", v, 8'h88);
    chk("R7 no rst in interval", {7'b0, rst_req_o}, 8'h00);
    bus_wr(1'b1, 16'hA588); chk("R8 write1 keeps", {7'b0, irq_o}, 8'h01);
    bus_wr(1'b1, 16'hA580); chk("R8 write0 clears", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_watchdog;
    logic [7:0] v;
    bus_wr(1'b1, 16'hA5E0);
    bus_wr(1'b0, 16'h5AFF);
    wait_edges(31); chk("R7 rst before wrap", {7'b0, rst_req_o}, 8'h00);
    wait_edges(1);
    chk("R7 rst pulse", {6'b0, rst_req_o, rst_kind_o}, 8'h03);
    rd(1'b1, v); chk("R7 wovf flag", v, 8'hF0);
    rd(1'b0, v); chk("R7 cnt wrapped", v, 8'h00);
    chk("R6 no irq in watchdog", {7'b0, irq_o}, 8'h00);
    wait_edges(1); chk("R7 pulse ends", {7'b0, rst_req_o}, 8'h00);
    bus_wr(1'b1, 16'hA560); rd(1'b1, v); chk("R8 wovf cleared", v, 8'h60);
    rd(1'b0, v);
    wait_edges(200);
    begin
      logic [7:0] w;
      rd(1'b0, w); chk("R5 stop counting", w, v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_keys();
    t_ratio();
    t_interval();
    t_watchdog();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog timeout actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule